// File: doc/BRIEF.md
# Modem Signal Change Detector

This block watches the ring-indicator and carrier-detect inputs of every serial line of a multi-line serial controller. It reports a new level only after that level has held without interruption for a qualifying time, nominally 100 ms. Each raw input first passes through a two-stage synchronizer. A per-signal qualification filter then compares the synchronized sample against the level it currently reports. While the two differ, the filter counts ticks of a shared millisecond prescaler. When the sample returns to the reported level, the count drops back to zero.

Once a change qualifies, the reported level is updated. In the same cycle, an interrupt-pending bit for that line is set. The reported levels form two host-visible detect vectors, one for ring and one for carrier, with one bit per line. The pending bits stay set until they are cleared by a write-one-to-clear strobe from the host or from the interrupt logic. The block does not drive modem outputs and does not deliver interrupts itself.

The parameters are the number of lines, the clock cycles per millisecond (T) and the stability time in milliseconds (S). A change is accepted on the (S+1)-th prescaler tick seen while the input differs. This guarantees at least S full milliseconds of stability.

Top module: `mdet_top`

## Requirements
- R1: After synchronous reset, every bit of ring_det, carr_det and pend is 0.
- R2: Ring and carrier of every line are filtered independently; bit i of ring_det and carr_det reports line i.
- R3: When a raw input changes at clock edge E0 and then stays at its new level, the matching detect bit keeps its old value through edge E0+1+S*T.
- R4: Under the same conditions, the detect bit shows the new level no later than edge E0+1+(S+1)*T.
- R5: Both rising (0 to 1) and falling (1 to 0) changes are qualified and reported.
- R6: An excursion of at most S*T cycles away from the reported level is never reported. Any return to the reported level, even for one cycle, restarts qualification, and no pending bit is set.
- R7: At the edge where a line's ring_det or carr_det changes, pend bit i becomes 1; a pending bit never rises without such a change.
- R8: While pend_clr_we is 1 at a clock edge, every pend bit whose pend_clr_mask bit is 1 is cleared. Pend bits whose mask bit is 0 keep their value.
- R9: When a qualified change and a clear of the same pend bit meet at one edge, the bit ends up set.
- R10: A change on one line, or on several lines at once, leaves the detect and pending bits of the other lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_raw | input | LINES | Asynchronous ring inputs, one per line |
| carr_raw | input | LINES | Asynchronous carrier inputs, one per line |
| pend_clr_we | input | 1 | Clear strobe for pending bits |
| pend_clr_mask | input | LINES | Pending bits to clear when pend_clr_we is 1 (1 = clear) |
| ring_det | output | LINES | Qualified ring levels |
| carr_det | output | LINES | Qualified carrier levels |
| pend | output | LINES | Per-line change-pending bits |

## Verification
Each line and each signal is toggled in both directions, with the start offset against the prescaler phase stepped through every value. Sampling just before the earliest permitted acceptance edge and just after the latest one separates a filter that is too eager from one that is too slow. Pulses of every length from one cycle up to S*T cycles, and a long train of pulses broken by one-cycle dips, show whether qualification restarts on a bounce. Simultaneous toggles on several lines, clears with mixed masks, and a clear held across the acceptance edge separate line cross-talk, wrong clear masking, and a clear that wins over a new event.

// File: rtl/mdet_pkg.sv
package mdet_pkg;
  // ring and carrier per line
  localparam int MDET_KINDS = 2;

  // number of ticks that must be observed while different so that at least
  // stable_ms whole milliseconds have elapsed regardless of tick phase
  function automatic int hold_ticks(input int stable_ms);
    return stable_ms + 1;
  endfunction
endpackage

// File: rtl/mdet_sync.sv
module mdet_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/mdet_tick.sv
module mdet_tick #(
  parameter int TICKS_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (TICKS_PER_MS <= 1) begin : g_every
      always_ff @(posedge clk) begin
        if (rst) tick <= 1'b0;
        else     tick <= 1'b1;
      end
    end else begin : g_div
      localparam int CW = $clog2(TICKS_PER_MS);
      localparam logic [CW-1:0] LAST = CW'(TICKS_PER_MS - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt  <= '0;
          tick <= 1'b0;
        end else begin
          tick <= (cnt == LAST);
          if (cnt == LAST) cnt <= '0;
          else             cnt <= cnt + 1'b1;
        end
      end

      // ticks are single-cycle pulses (timing basis of R3/R4)
      assert_tick_single_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/mdet_filter.sv
module mdet_filter #(
  parameter int HOLD_TICKS = 101
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic smp,
  output logic level,
  output logic accept
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt;
  logic          differ;
  logic          at_last;

  always_comb begin
    differ  = (smp != level);
    at_last = (cnt == LAST);
    accept  = differ && tick && at_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      cnt   <= '0;
    end else if (!differ) begin
      cnt <= '0;
    end else if (tick) begin
      if (at_last) begin
        level <= smp;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // level only moves on a prescaler tick
  assert_level_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (level != $past(level)) |-> $past(tick));
  // level only moves to the sampled input value
  assert_level_follows_sample_R2: assert property (@(posedge clk) disable iff (rst)
    (level != $past(level)) |-> (level == $past(smp)));
  // a return to the reported level clears the qualification count
  assert_bounce_restarts_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(smp) == $past(level)) |-> (cnt == '0));
  assert_count_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/mdet_top.sv
module mdet_top #(
  parameter int LINES        = 16,
  parameter int TICKS_PER_MS = 50000,
  parameter int STABLE_MS    = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] ring_raw,
  input  logic [LINES-1:0] carr_raw,
  input  logic             pend_clr_we,
  input  logic [LINES-1:0] pend_clr_mask,
  output logic [LINES-1:0] ring_det,
  output logic [LINES-1:0] carr_det,
  output logic [LINES-1:0] pend
);
  import mdet_pkg::*;

  localparam int NSIG = LINES * MDET_KINDS;
  localparam int HOLD = hold_ticks(STABLE_MS);

  logic [NSIG-1:0] raw_all;
  logic [NSIG-1:0] smp_all;
  logic [NSIG-1:0] lvl_all;
  logic [NSIG-1:0] acc_all;
  logic            tick;

  assign raw_all = {carr_raw, ring_raw};

  mdet_sync #(.WIDTH(NSIG)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw_all),
    .dout (smp_all)
  );

  mdet_tick #(.TICKS_PER_MS(TICKS_PER_MS)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  generate
    for (genvar s = 0; s < NSIG; s++) begin : g_sig
      mdet_filter #(.HOLD_TICKS(HOLD)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .smp    (smp_all[s]),
        .level  (lvl_all[s]),
        .accept (acc_all[s])
      );
    end
  endgenerate

  assign ring_det = lvl_all[LINES-1:0];
  assign carr_det = lvl_all[NSIG-1:LINES];

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      logic set_i;
      assign set_i = acc_all[i] | acc_all[LINES + i];

      always_ff @(posedge clk) begin
        if (rst)                                pend[i] <= 1'b0;
        else if (set_i)                         pend[i] <= 1'b1;
        else if (pend_clr_we && pend_clr_mask[i]) pend[i] <= 1'b0;
      end

      // a change of a detect bit raises pending in the same cycle (set wins)
      assert_change_sets_pend_R9: assert property (@(posedge clk) disable iff (rst)
        ((ring_det[i] != $past(ring_det[i])) || (carr_det[i] != $past(carr_det[i])))
          |-> pend[i]);
      // pending never rises without a detect change
      assert_pend_needs_change_R7: assert property (@(posedge clk) disable iff (rst)
        (pend[i] && !$past(pend[i]))
          |-> ((ring_det[i] != $past(ring_det[i])) || (carr_det[i] != $past(carr_det[i]))));
      // pending is held unless a clear addressed it
      assert_pend_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(pend[i]) && !($past(pend_clr_we) && $past(pend_clr_mask[i]))) |-> pend[i]);
    end
  endgenerate
endmodule

// File: tb/sim_mdet_top.sv
module sim_mdet_top;
  localparam int N  = 4;
  localparam int T  = 3;
  localparam int S  = 4;
  localparam int H  = S + 1;
  localparam int K_OLD = 2 + S * T;      // posedges after change: still old
  localparam int K_NEW = 2 + H * T;      // posedges after change: new level

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] ring_raw, carr_raw, pend_clr_mask;
  logic         pend_clr_we;
  logic [N-1:0] ring_det, carr_det, pend;
  logic [N-1:0] exp_ring, exp_carr, exp_pend;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mdet_top #(.LINES(N), .TICKS_PER_MS(T), .STABLE_MS(S)) u0 (
    .clk(clk), .rst(rst), .ring_raw(ring_raw), .carr_raw(carr_raw),
    .pend_clr_we(pend_clr_we), .pend_clr_mask(pend_clr_mask),
    .ring_det(ring_det), .carr_det(carr_det), .pend(pend)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_all(input string req);
    chk(ring_det == exp_ring, req, "ring_det", int'(ring_det), int'(exp_ring));
    chk(carr_det == exp_carr, req, "carr_det", int'(carr_det), int'(exp_carr));
    chk(pend == exp_pend, req, "pend", int'(pend), int'(exp_pend));
  endtask

  task automatic clear(input logic [N-1:0] mask);
    pend_clr_we   = 1'b1;
    pend_clr_mask = mask;
    @(posedge clk);
    @(negedge clk);
    pend_clr_we   = 1'b0;
    pend_clr_mask = '0;
    exp_pend = exp_pend & ~mask;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ring_raw = '0; carr_raw = '0;
    pend_clr_we = 1'b0; pend_clr_mask = '0;
    exp_ring = '0; exp_carr = '0; exp_pend = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk_all("R1");

    // sweep: every line, both signals, both directions, varying tick phase
    for (int line = 0; line < N; line++) begin
      for (int kind = 0; kind < 2; kind++) begin
        for (int dir = 0; dir < 2; dir++) begin
          int idx = (line * 4) + (kind * 2) + dir;
          if (idx % T != 0) step((idx % T) - 1);
          if (kind == 0) ring_raw[line] = ~ring_raw[line];
          else           carr_raw[line] = ~carr_raw[line];
          step(K_OLD);
          chk_all("R3");
          step(K_NEW - K_OLD);
          if (kind == 0) exp_ring[line] = ~exp_ring[line];
          else           exp_carr[line] = ~exp_carr[line];
          exp_pend[line] = 1'b1;
          chk_all(dir == 0 ? "R4" : "R5");
          chk_all("R7");
          chk_all("R10");
          // mask that skips this line leaves it pending
          clear(~(N'(1) << line));
          chk(pend[line] == 1'b1, "R8", "unmasked bit kept", int'(pend), int'(exp_pend));
          clear(N'(1) << line);
          chk_all("R8");
        end
      end
    end

    // bounce: pulses of every length up to S*T cycles are never reported
    for (int len = 1; len <= S * T; len++) begin
      carr_raw[1] = 1'b1;
      repeat (len) @(negedge clk);
      carr_raw[1] = 1'b0;
      step(K_NEW + 2);
      chk_all("R6");
    end

    // long high time broken by one-cycle dips is never reported
    for (int p = 0; p < 6; p++) begin
      ring_raw[3] = 1'b1;
      repeat (S * T - 1) @(negedge clk);
      ring_raw[3] = 1'b0;
      @(negedge clk);
    end
    step(K_NEW + 2);
    chk_all("R6");

    // several lines and both signals at once
    ring_raw[0] = 1'b1; carr_raw[0] = 1'b1; carr_raw[3] = 1'b1;
    step(K_OLD);
    chk_all("R3");
    step(K_NEW - K_OLD);
    exp_ring[0] = 1'b1; exp_carr[0] = 1'b1; exp_carr[3] = 1'b1;
    exp_pend = 4'b1001;
    chk_all("R10");
    chk_all("R2");
    clear(4'b1111);
    chk_all("R8");

    // clear held across the acceptance edge: set wins
    begin
      logic old_v;
      int waited;
      old_v = ring_det[2];
      pend_clr_we = 1'b1;
      pend_clr_mask = '1;
      ring_raw[2] = ~ring_raw[2];
      waited = 0;
      while (ring_det[2] == old_v && waited < 40) begin
        @(negedge clk);
        waited++;
      end
      chk(ring_det[2] != old_v, "R9", "change seen", int'(ring_det[2]), int'(~old_v));
      chk(pend[2] == 1'b1, "R9", "set beats clear", int'(pend[2]), 1);
      @(negedge clk);
      chk(pend[2] == 1'b0, "R8", "held clear applies", int'(pend[2]), 0);
      pend_clr_we = 1'b0;
      pend_clr_mask = '0;
      exp_ring[2] = ~old_v;
      exp_pend = '0;
      chk_all("R10");
    end

    // reset in the middle of activity
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    exp_ring = '0; exp_carr = '0; exp_pend = '0;
    chk_all("R1");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule